// File: doc/BRIEF.md
# Multi-Address I2C Slave Controller

This block is the target side of an I2C bus that answers to up to four 7-bit addresses at once. SCL and SDA are brought into the core clock domain through a synchroniser. START and STOP are found from SDA edges while SCL is high. After a START the block shifts in the address and the R/W bit, and compares the address with every enabled slot. It then reports the winning slot as a one-hot code. It either acknowledges and enters a transmit or receive path, or it goes quiet until the bus is restarted or stopped. SDA is open-drain: the block only ever pulls it low through `sda_oe`.

Data moves through two one-byte buffers, each with a valid/ready handshake. Received bytes appear on `rx_data` with `rx_valid` held high until the consumer takes them with `rx_ready`. A byte that completes while the buffer is still occupied is dropped and flagged. Bytes to send are offered on `tx_data` with `tx_valid`. They are accepted only while `tx_ready` is high, which means the transmit buffer is empty. Six sticky event flags, together with busy, bus-active, direction and matched-slot outputs, give the status.

Top module: `i2c_multi_slave`

## Requirements
- R1: A START (SDA falling while SCL is high, repeated START included) sets flag bit 0, `bus_active` and `busy`, and restarts address reception from the first bit.
- R2: The address phase samples SDA on eight SCL rising edges. The first seven bits are the address, MSB first, and the eighth is R/W (1 = master reads).
- R3: The address is compared with every slot whose `slot_en` bit is set. `matched` takes the value 1, 2, 4 or 8 for slot 0, 1, 2 or 3, and the lowest matching slot wins. With no match, `matched` becomes 0 and `busy` clears. No ACK is driven, and the block ignores the bus until the next START or STOP.
- R4: On a match, the block drives `ack_val` on SDA during the ninth clock (`ack_val`=0 pulls SDA low). It also sets flag bit 1 and sets `mode_tx` to the R/W bit.
- R5: In transmit mode, each byte comes from the transmit buffer and goes out MSB first. The buffer is emptied when the byte is loaded. An empty buffer sends 0xFF.
- R6: After the eighth transmitted bit, flag bit 2 is set and `busy` clears. Accepting a byte on the transmit handshake sets `busy`.
- R7: On the master's acknowledge bit after a transmitted byte, flag bit 5 is set if SDA differs from `ack_val`. If SDA is high, transmission ends and SDA is left released until the next START or STOP.
- R8: In receive mode, eight bits are shifted in MSB first. On the eighth rising edge the byte is loaded into the receive buffer, `rx_valid` rises and flag bit 3 is set. `ack_val` is then driven during the ninth clock.
- R9: If a byte completes while `rx_valid` is high and `rx_ready` is low, flag bit 4 is set and flag bit 3 is not. The new byte is discarded, and the buffered byte stays unchanged.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle and clears `bus_active` and `busy`. The flags are left as they are. After reset, all outputs are 0 except `tx_ready`.
- R11: The flags are sticky and are cleared only by writing 1 to the matching `flag_clr` bit. Bits not written keep their value.
- R12: `sda_oe` is only asserted while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| slot_addr | input | SLOTS*AW | Four 7-bit slave addresses, slot 0 in the low bits |
| slot_en | input | SLOTS | Per-slot enable |
| ack_val | input | 1 | Level driven in acknowledge slots, and the expected master acknowledge |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit buffer empty, byte can be accepted |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_ready | input | 1 | Consumer takes the buffered byte |
| rx_data | output | 8 | Received byte |
| flag_clr | input | 6 | Write-one-to-clear for the flags |
| irq_flags | output | 6 | Sticky flags: 0 start, 1 match, 2 tx done, 3 rx done, 4 overrun, 5 nack |
| busy | output | 1 | Engine busy |
| bus_active | output | 1 | Between START and STOP |
| mode_tx | output | 1 | 1 = transmit path selected |
| matched | output | SLOTS | One-hot matched slot |

## Verification
The checks assume SCL stays high and low for much longer than the two-stage synchroniser plus edge register (several core clocks). They also assume the master moves SDA only while SCL is low, except for START and STOP, and never stretches SCL. The bench master uses quarter-bit phases of ten core clocks and changes its own SDA a full quarter-bit after each SCL edge. This keeps the slave's drive changes, which follow the falling edge by about three clocks, clear of the master's. Transmit bytes are offered between the eighth data bit and the acknowledge bit, so they land before the next load.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 6;
  localparam int FL_START  = 0;
  localparam int FL_AMATCH = 1;
  localparam int FL_TXDONE = 2;
  localparam int FL_RXDONE = 3;
  localparam int FL_OVR    = 4;
  localparam int FL_NACK   = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_AEND,
    ST_TXB,
    ST_TXREL,
    ST_TXCHK,
    ST_RXB,
    ST_RXACK,
    ST_RXEND
  } eng_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_ff[k] <= scl_ff[k-1];
        sda_ff[k] <= sda_ff[k-1];
      end
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
  parameter int SLOTS = 4,
  parameter int AW    = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0][AW-1:0]  slot_addr,
  input  logic [SLOTS-1:0]          slot_en,
  input  logic [AW-1:0]             rx_addr,
  output logic [SLOTS-1:0]          hit_oh
);
  logic [SLOTS-1:0] raw_hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign raw_hit[g] = slot_en[g] && (slot_addr[g] == rx_addr);
  end

  // lowest slot index has priority
  always_comb begin
    hit_oh = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (raw_hit[k]) hit_oh = SLOTS'(1) << k;
    end
  end

  // R3
  hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_oh != '0) |-> ((hit_oh & slot_en) == hit_oh));
endmodule

// File: rtl/i2cs_byte_bufs.sv
module i2cs_byte_bufs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_take,
  output logic [DW-1:0] tx_byte,
  output logic          tx_accept,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_overrun
);
  logic          tx_full;
  logic [DW-1:0] tx_hold;

  assign tx_ready   = ~tx_full;
  assign tx_accept  = tx_valid & tx_ready;
  assign tx_byte    = tx_full ? tx_hold : '1;
  assign rx_overrun = rx_push & rx_valid & ~rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else begin
      if (tx_take) tx_full <= 1'b0;
      if (tx_accept) begin
        tx_full <= 1'b1;
        tx_hold <= tx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (rx_push && !rx_overrun) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // R9
  overrun_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> (rx_valid && $stable(rx_data)));
endmodule

// File: rtl/i2c_multi_slave.sv
module i2c_multi_slave
  import i2cs_pkg::*;
#(
  parameter int SLOTS       = 4,
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic [SLOTS-1:0][AW-1:0] slot_addr,
  input  logic [SLOTS-1:0]         slot_en,
  input  logic                     ack_val,
  input  logic                     tx_valid,
  output logic                     tx_ready,
  input  logic [BYTE_W-1:0]        tx_data,
  output logic                     rx_valid,
  input  logic                     rx_ready,
  output logic [BYTE_W-1:0]        rx_data,
  input  logic [FLAG_W-1:0]        flag_clr,
  output logic [FLAG_W-1:0]        irq_flags,
  output logic                     busy,
  output logic                     bus_active,
  output logic                     mode_tx,
  output logic [SLOTS-1:0]         matched
);
  localparam int CW = $clog2(BYTE_W) + 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  eng_state_t state;
  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] shreg, shin, tx_byte;
  logic [SLOTS-1:0]  hit_oh;
  logic [FLAG_W-1:0] fset;
  logic last_rise, addr_done, mismatch_evt, txdone_evt;
  logic tx_take, tx_accept, rx_push, rx_overrun;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign shin = {shreg[BYTE_W-2:0], sda_s};

  i2cs_addr_match #(.SLOTS(SLOTS), .AW(AW)) u_match (
    .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .slot_en(slot_en),
    .rx_addr(shin[BYTE_W-1 -: AW]), .hit_oh(hit_oh)
  );

  i2cs_byte_bufs #(.DW(BYTE_W)) u_bufs (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_take(tx_take), .tx_byte(tx_byte), .tx_accept(tx_accept),
    .rx_push(rx_push), .rx_byte(shin), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_overrun(rx_overrun)
  );

  assign last_rise    = scl_rise && (bit_cnt == LAST_BIT);
  assign addr_done    = !start_det && !stop_det && (state == ST_ADDR) && last_rise;
  assign mismatch_evt = addr_done && (hit_oh == '0);
  assign txdone_evt   = !start_det && !stop_det && (state == ST_TXB) && last_rise;
  assign rx_push      = !start_det && !stop_det && (state == ST_RXB) && last_rise;
  assign tx_take      = !start_det && !stop_det && (state == ST_AEND) && scl_fall && mode_tx;

  always_comb begin
    fset = '0;
    fset[FL_START]  = start_det;
    fset[FL_AMATCH] = addr_done && (hit_oh != '0);
    fset[FL_TXDONE] = txdone_evt;
    fset[FL_RXDONE] = rx_push && !rx_overrun;
    fset[FL_OVR]    = rx_overrun;
    fset[FL_NACK]   = !start_det && !stop_det && (state == ST_TXCHK) &&
                      scl_rise && (sda_s != ack_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flags <= '0;
    else        irq_flags <= (irq_flags & ~flag_clr) | fset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            busy <= 1'b0;
    else if (stop_det)                     busy <= 1'b0;
    else if (start_det || tx_accept)       busy <= 1'b1;
    else if (mismatch_evt || txdone_evt)   busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_oe     <= 1'b0;
      bus_active <= 1'b0;
      mode_tx    <= 1'b0;
      matched    <= '0;
    end else if (start_det) begin
      state      <= ST_ADDR;
      bit_cnt    <= '0;
      sda_oe     <= 1'b0;
      bus_active <= 1'b1;
    end else if (stop_det) begin
      state      <= ST_IDLE;
      sda_oe     <= 1'b0;
      bus_active <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (scl_rise) begin
          shreg   <= shin;
          bit_cnt <= bit_cnt + 1'b1;
          if (last_rise) begin
            matched <= hit_oh;
            if (hit_oh != '0) begin
              mode_tx <= shin[0];
              state   <= ST_AACK;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_oe <= ~ack_val;
          state  <= ST_AEND;
        end
        ST_AEND: if (scl_fall) begin
          bit_cnt <= '0;
          if (mode_tx) begin
            shreg  <= tx_byte;
            sda_oe <= ~tx_byte[BYTE_W-1];
            state  <= ST_TXB;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_RXB;
          end
        end
        ST_TXB: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (last_rise) state <= ST_TXREL;
          end
          if (scl_fall) begin
            shreg  <= shreg << 1;
            sda_oe <= ~shreg[BYTE_W-2];
          end
        end
        ST_TXREL: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= ST_TXCHK;
        end
        ST_TXCHK: if (scl_rise) begin
          state <= sda_s ? ST_IDLE : ST_AEND;
        end
        ST_RXB: if (scl_rise) begin
          shreg   <= shin;
          bit_cnt <= bit_cnt + 1'b1;
          if (last_rise) state <= ST_RXACK;
        end
        ST_RXACK: if (scl_fall) begin
          sda_oe <= ~ack_val;
          state  <= ST_RXEND;
        end
        ST_RXEND: if (scl_fall) begin
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
          state   <= ST_RXB;
        end
        default: ;
      endcase
    end
  end

  // R1
  start_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (busy && bus_active && irq_flags[FL_START]));

  // R10
  stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!busy && !bus_active && state == ST_IDLE));

  // R4
  ack_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AACK && scl_fall && !start_det && !stop_det) |=> (sda_oe == !$past(ack_val)));

  // R11
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_flags & $past(irq_flags & ~flag_clr)) == $past(irq_flags & ~flag_clr)));

  // R12
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: tb/i2c_multi_slave_bench.sv
module i2c_multi_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [3:0][6:0] slot_addr;
  logic [3:0] slot_en = 4'b1111;
  logic ack_val = 1'b0;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic [5:0] flag_clr = '0, irq_flags;
  logic busy, bus_active, mode_tx;
  logic [3:0] matched;

  int checks = 0, fails = 0, r12_viol = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_multi_slave u_i2c_multi_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .slot_addr(slot_addr), .slot_en(slot_en), .ack_val(ack_val),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .flag_clr(flag_clr), .irq_flags(irq_flags), .busy(busy),
    .bus_active(bus_active), .mode_tx(mode_tx), .matched(matched)
  );

  // R12 monitor: slave drive must not rise while the master holds SCL high
  logic oe_q = 1'b0;
  always @(posedge clk) begin
    if (rst_n && sda_oe && !oe_q && scl_m) r12_viol++;
    oe_q <= sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(); repeat (Q) @(posedge clk); #1; endtask
  task automatic m_start(); sda_m = 1; wait_q(); scl_m = 1; wait_q(); sda_m = 0; wait_q(); scl_m = 0; wait_q(); endtask
  task automatic m_stop(); sda_m = 0; wait_q(); scl_m = 1; wait_q(); sda_m = 1; wait_q(); endtask
  task automatic m_wbit(logic b); sda_m = b; wait_q(); scl_m = 1; wait_q(); wait_q(); scl_m = 0; wait_q(); endtask
  task automatic m_rbit(output logic b); sda_m = 1; wait_q(); scl_m = 1; wait_q(); b = sda_line; wait_q(); scl_m = 0; wait_q(); endtask

  task automatic m_wbyte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    m_rbit(ack);
  endtask

  task automatic m_rbits(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      m_rbit(b);
      v[i] = b;
    end
  endtask

  task automatic pulse_clr(logic [5:0] m);
    @(posedge clk); #1; flag_clr = m; @(posedge clk); #1; flag_clr = '0;
  endtask

  task automatic push_tx(logic [7:0] v);
    @(posedge clk); #1; tx_valid = 1; tx_data = v; @(posedge clk); #1; tx_valid = 0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R10 reset busy", busy, 0);
    chk("R10 reset bus_active", bus_active, 0);
    chk("R10 reset flags", irq_flags, 0);
    chk("R10 reset matched", matched, 0);
    chk("R10 reset rx_valid", rx_valid, 0);
    chk("R10 reset tx_ready", tx_ready, 1);
    chk("R10 reset sda_oe", sda_oe, 0);
  endtask

  task automatic t_write();
    logic a;
    m_start();
    chk("R1 start busy", busy, 1);
    chk("R1 start bus_active", bus_active, 1);
    chk("R1 start flag", irq_flags[0], 1);
    m_wbyte({7'h35, 1'b0}, a);
    chk("R4 ack low", a, 0);
    chk("R2 R3 priority match", matched, 4'b0010);
    chk("R4 match flag", irq_flags[1], 1);
    chk("R4 mode rx", mode_tx, 0);
    m_wbyte(8'hA6, a);
    chk("R8 ack", a, 0);
    chk("R8 rx_valid", rx_valid, 1);
    chk("R8 rx_data", rx_data, 8'hA6);
    chk("R8 rx flag", irq_flags[3], 1);
    m_wbyte(8'h3C, a);
    chk("R9 overrun flag", irq_flags[4], 1);
    chk("R9 old byte kept", rx_data, 8'hA6);
    m_stop();
    chk("R10 stop busy", busy, 0);
    chk("R10 stop bus_active", bus_active, 0);
    chk("R10 flags kept", irq_flags, 6'h1B);
    pulse_clr(6'h01);
    chk("R11 partial clear", irq_flags, 6'h1A);
    pulse_clr(6'h3F);
    chk("R11 full clear", irq_flags, 0);
    @(posedge clk); #1; rx_ready = 1; @(posedge clk); #1; rx_ready = 0;
    chk("R8 rx popped", rx_valid, 0);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    push_tx(8'hC5);
    chk("R6 write sets busy", busy, 1);
    chk("R5 tx buffer full", tx_ready, 0);
    m_start();
    m_wbyte({7'h50, 1'b1}, a);
    chk("R4 read ack", a, 0);
    chk("R3 slot2 code", matched, 4'b0100);
    chk("R4 mode tx", mode_tx, 1);
    m_rbits(d);
    chk("R5 byte msb first", d, 8'hC5);
    chk("R6 txdone flag", irq_flags[2], 1);
    chk("R6 busy cleared", busy, 0);
    m_wbit(1'b0);
    chk("R5 buffer emptied", tx_ready, 1);
    m_rbits(d);
    chk("R5 empty sends ff", d, 8'hFF);
    push_tx(8'h3E);
    chk("R6 write sets busy again", busy, 1);
    chk("R7 no nack yet", irq_flags[5], 0);
    m_wbit(1'b0);
    m_rbits(d);
    chk("R5 second byte", d, 8'h3E);
    m_wbit(1'b1);
    chk("R7 nack flag", irq_flags[5], 1);
    m_rbits(d);
    chk("R7 released after nack", d, 8'hFF);
    m_stop();
    pulse_clr(6'h3F);
  endtask

  task automatic t_mismatch();
    logic a;
    slot_en = 4'b1011;
    m_start();
    m_wbyte({7'h50, 1'b0}, a);
    chk("R3 no ack", a, 1);
    chk("R3 matched zero", matched, 0);
    chk("R3 busy cleared", busy, 0);
    m_wbyte(8'h00, a);
    chk("R3 ignored no ack", a, 1);
    chk("R3 ignored rx", rx_valid, 0);
    chk("R3 only start flag", irq_flags, 6'h01);
    m_stop();
    slot_en = 4'b1111;
    pulse_clr(6'h3F);
  endtask

  task automatic t_ackval();
    logic a;
    ack_val = 1'b1;
    m_start();
    m_wbyte({7'h21, 1'b0}, a);
    chk("R4 ack_val high", a, 1);
    chk("R3 slot0 code", matched, 4'b0001);
    m_wbyte(8'h5A, a);
    chk("R8 data with ack_val high", rx_data, 8'h5A);
    m_stop();
    ack_val = 1'b0;
    @(posedge clk); #1; rx_ready = 1; @(posedge clk); #1; rx_ready = 0;
    pulse_clr(6'h3F);
  endtask

  task automatic t_restart();
    logic a;
    m_start();
    m_wbyte({7'h21, 1'b0}, a);
    m_wbit(1); m_wbit(0); m_wbit(1);
    pulse_clr(6'h3F);
    m_start();
    chk("R1 restart flag", irq_flags[0], 1);
    m_wbyte({7'h35, 1'b1}, a);
    chk("R1 restart realigns ack", a, 0);
    chk("R1 restart match", matched, 4'b0010);
    chk("R1 restart mode", mode_tx, 1);
    chk("R8 partial byte dropped", rx_valid, 0);
    m_stop();
    chk("R10 stop after restart", bus_active, 0);
  endtask

  initial begin
    slot_addr[0] = 7'h21;
    slot_addr[1] = 7'h35;
    slot_addr[2] = 7'h50;
    slot_addr[3] = 7'h35;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_write();
    t_read();
    t_mismatch();
    t_ackval();
    t_restart();
    chk("R12 drive only while scl low", r12_viol, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule